// File: doc/BRIEF.md
# Latched-Input GPIO Port with Change Interrupts

This block is a bank of general-purpose pins with the registers that run them. A host reaches the registers through a plain address/data port with one-cycle write and read strobes. It sets each pin's direction, the level it drives, an optional inversion of what it reads back, and how pin changes raise an interrupt. Pin inputs pass through a synchronizer. Each synchronized level is compared with a per-pin reference, which is the level seen the last time the host read the input register. An unmasked difference raises an active-low interrupt. That interrupt is modelled as an enable that pulls a shared line low.

Two options shape the interrupt path. With a pin's latch bit set, the first change on that pin is captured and held, together with its interrupt, until the host reads the input register, even if the pin has already gone back to its old level. With the latch bit clear, the interrupt simply follows the difference. A read-only status register shows which pins are currently requesting. One bank-wide bit chooses push-pull or open-drain output stages. Pull-resistor settings are kept as storage only.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset, direction (0x0) reads 0xFF, output (0x1) 0x00, inversion (0x2) 0x00, latch enable (0x4) 0x00, mask (0x5) 0xFF and port config (0x7) 0x00; no pin output enable is asserted and `irq_oe` is 0.
- R2: A pin whose mask bit is 1 never sets its status bit (0x6) and never asserts `irq_oe`, whatever its input does.
- R3: `irq_oe` is 1 exactly when some status bit is 1; a status bit of an unmasked pin rises within four clocks after its input level starts to differ from that pin's reference.
- R4: An input register (0x3) read returns, for every pin, the observed level XOR its inversion bit.
- R5: With its latch bit 0, an unmasked pin's status bit clears again when its input returns to the reference level, with no read.
- R6: With its latch bit 1, an unmasked pin's first change is held: its status bit stays 1 and an input register read returns the changed level, even after the pin returns.
- R7: Reading the input register clears every held change, makes the current levels the new references, and so clears `irq_oe`; reading the status register has no side effect.
- R8: With port config bit 0 = 1 (open-drain), an output pin's enable is asserted only when its output bit is 0, and `pin_out` is 0.
- R9: A direction bit of 1 makes the pin an input (enable off); in push-pull mode an output pin is enabled and `pin_out` carries the output register bit.
- R10: Reading the output register returns the stored value, not the pin level.
- R11: Writes to the input (0x3) and status (0x6) addresses are ignored; pull enable (0x8) and pull select (0x9) are plain read/write storage; read data appears on `rd_data` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | N | Write data |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_data | output | N | Read data, registered |
| pin_in | input | N | Raw pin levels |
| pin_oe | output | N | Per-pin output enable |
| pin_out | output | N | Per-pin driven level |
| irq_oe | output | 1 | 1 pulls the interrupt line low |

## Verification
The change-detect path is tried with several toggle patterns. An all-pin swing while every pin is masked checks that masking blocks the interrupt. A pulse that returns to its old level on an unlatched pin checks that the interrupt follows the difference. The same pulse on a latched pin checks that the change is held until a read. A second change followed by an input read checks that the read clears the interrupt and moves the reference. The output patterns compare push-pull and open-drain mode on the same output value, which separates how the direction bit and the mode bit each act on the enables.

// File: rtl/gpio_latch_pkg.sv
`timescale 1ns/1ps
package gpio_latch_pkg;
   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RA_DIR     = 4'h0,
      RA_OUT     = 4'h1,
      RA_INV     = 4'h2,
      RA_IN      = 4'h3,
      RA_LATCH   = 4'h4,
      RA_MASK    = 4'h5,
      RA_STAT    = 4'h6,
      RA_PCFG    = 4'h7,
      RA_PULLEN  = 4'h8,
      RA_PULLSEL = 4'h9
   } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
`timescale 1ns/1ps
module gpio_chg_detect #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] latch_en,
   input  logic         in_read,
   output logic [W-1:0] in_view,
   output logic [W-1:0] stat,
   output logic [W-1:0] held_pend
);
   generate
      for (genvar i = 0; i < int'(W); i++) begin : g_pin
         logic ref_q, cap_q, pend_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ref_q  <= 1'b0;
               cap_q  <= 1'b0;
               pend_q <= 1'b0;
            end else if (in_read) begin
               ref_q  <= lvl[i];
               cap_q  <= lvl[i];
               pend_q <= 1'b0;
            end else begin
               if (mask[i]) ref_q <= lvl[i];
               if (!pend_q) cap_q <= lvl[i];
               if (latch_en[i] && !mask[i] && (lvl[i] != ref_q)) pend_q <= 1'b1;
            end
         end

         assign stat[i]      = !mask[i] && (latch_en[i] ? pend_q : (lvl[i] != ref_q));
         assign in_view[i]   = (latch_en[i] && pend_q) ? cap_q : lvl[i];
         assign held_pend[i] = pend_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_out_drive.sv
`timescale 1ns/1ps
module gpio_out_drive #(
   parameter int unsigned W     = 8,
   parameter bit          OD_EN = 1'b1
) (
   input  logic [W-1:0] dir,
   input  logic [W-1:0] out_val,
   input  logic         od_mode,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] pin_out
);
   generate
      if (OD_EN) begin : g_od
         assign pin_oe  = od_mode ? (~dir & ~out_val) : ~dir;
         assign pin_out = od_mode ? '0 : out_val;
      end else begin : g_pp
         assign pin_oe  = ~dir;
         assign pin_out = out_val;
      end
   endgenerate
endmodule

// File: rtl/gpio_latch_port.sv
`timescale 1ns/1ps
module gpio_latch_port
   import gpio_latch_pkg::*;
#(
   parameter int unsigned N           = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OD_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] addr,
   input  logic              wr_en,
   input  logic [N-1:0]      wr_data,
   input  logic              rd_en,
   output logic [N-1:0]      rd_data,
   input  logic [N-1:0]      pin_in,
   output logic [N-1:0]      pin_oe,
   output logic [N-1:0]      pin_out,
   output logic              irq_oe
);
   generate
      if (N < 2 || N > 32) begin : g_bad_width
         $error("gpio_latch_port: N must be 2..32");
      end
   endgenerate

   logic [N-1:0] dir_q, out_q, inv_q, latch_q, mask_q, pull_en_q, pull_sel_q;
   logic         od_q;
   logic [N-1:0] lvl, in_view, stat, held_pend, rd_mux;
   logic         in_read;

   assign in_read = rd_en && (addr == RA_IN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= '1;
         out_q      <= '0;
         inv_q      <= '0;
         latch_q    <= '0;
         mask_q     <= '1;
         od_q       <= 1'b0;
         pull_en_q  <= '0;
         pull_sel_q <= '0;
      end else if (wr_en) begin
         case (addr)
            RA_DIR:     dir_q      <= wr_data;
            RA_OUT:     out_q      <= wr_data;
            RA_INV:     inv_q      <= wr_data;
            RA_LATCH:   latch_q    <= wr_data;
            RA_MASK:    mask_q     <= wr_data;
            RA_PCFG:    od_q       <= wr_data[0];
            RA_PULLEN:  pull_en_q  <= wr_data;
            RA_PULLSEL: pull_sel_q <= wr_data;
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RA_DIR:     rd_mux = dir_q;
         RA_OUT:     rd_mux = out_q;
         RA_INV:     rd_mux = inv_q;
         RA_IN:      rd_mux = in_view ^ inv_q;
         RA_LATCH:   rd_mux = latch_q;
         RA_MASK:    rd_mux = mask_q;
         RA_STAT:    rd_mux = stat;
         RA_PCFG:    rd_mux = N'(od_q);
         RA_PULLEN:  rd_mux = pull_en_q;
         RA_PULLSEL: rd_mux = pull_sel_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   gpio_in_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_chg_detect #(.W(N)) u_chg (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .mask(mask_q), .latch_en(latch_q),
      .in_read(in_read), .in_view(in_view), .stat(stat), .held_pend(held_pend)
   );

   gpio_out_drive #(.W(N), .OD_EN(OD_EN)) u_drv (
      .dir(dir_q), .out_val(out_q), .od_mode(od_q), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   assign irq_oe = |stat;
endmodule

// File: rtl/gpio_latch_port_chk.sv
`timescale 1ns/1ps
module gpio_latch_port_chk
   import gpio_latch_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter bit          OD_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [REG_AW-1:0] addr,
   input logic [N-1:0]      dir_q,
   input logic [N-1:0]      mask_q,
   input logic              od_q,
   input logic [N-1:0]      held_pend,
   input logic [N-1:0]      stat,
   input logic [N-1:0]      pin_oe,
   input logic [N-1:0]      pin_out,
   input logic              irq_oe
);
   // R1: first cycle out of reset drives nothing and requests nothing
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !$past(rst_n)) |-> (pin_oe == '0 && !irq_oe));

   // R2: masked pins never show status
   a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & mask_q) == '0);

   // R3: an interrupt needs at least one unmasked pin
   a_r3_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe |-> (mask_q != '1));

   // R6: a held change survives until an input read
   a_r6_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == RA_IN) |=> ((held_pend & $past(held_pend)) == $past(held_pend)));

   // R7: an input read drops every held change
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == RA_IN) |=> (held_pend == '0));

   // R8: open-drain never drives a high level
   a_r8_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (OD_EN && od_q) |-> ((pin_oe & pin_out) == '0));

   // R9: an input pin is never driven
   a_r9_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & dir_q) == '0);
endmodule

bind gpio_latch_port gpio_latch_port_chk #(.N(N), .OD_EN(OD_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .dir_q(dir_q),
   .mask_q(mask_q), .od_q(od_q), .held_pend(held_pend), .stat(stat),
   .pin_oe(pin_oe), .pin_out(pin_out), .irq_oe(irq_oe)
);

// File: tb/gpio_latch_port_bench.sv
`timescale 1ns/1ps
module gpio_latch_port_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   addr = '0;
   logic         wr_en = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic         rd_en = 1'b0;
   logic [N-1:0] rd_data;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_oe, pin_out;
   logic         irq_oe;

   always #2.5 clk = ~clk;

   gpio_latch_port #(.N(N)) u_gpio_latch_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .irq_oe(irq_oe)
   );

   typedef struct {
      logic [N-1:0] data;
      string        tag;
   } exp_t;
   exp_t sb[$];

   int checks = 0;
   int bad = 0;
   logic fire = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: issues a read and pushes the expected value
   task automatic rd_exp(input logic [3:0] a, input logic [N-1:0] e, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      sb.push_back('{data: e, tag: tag});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_pins(input logic [N-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   // monitor: compares each read result with the scoreboard head
   always @(posedge clk) fire <= rd_en;
   always @(negedge clk) begin
      if (fire) begin
         if (sb.size() == 0) chk("scoreboard underflow", 1, 0);
         else begin
            exp_t it;
            it = sb.pop_front();
            chk(it.tag, 32'(rd_data), 32'(it.data));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pin_oe in reset", 32'(pin_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", 32'(irq_oe), 0);
      chk("R1 pin_oe after reset", 32'(pin_oe), 0);
      rd_exp(4'h0, 8'hFF, "R1 dir default");
      rd_exp(4'h1, 8'h00, "R1 out default");
      rd_exp(4'h2, 8'h00, "R1 inv default");
      rd_exp(4'h4, 8'h00, "R1 latch default");
      rd_exp(4'h5, 8'hFF, "R1 mask default");
      rd_exp(4'h7, 8'h00, "R1 pcfg default");

      // R2: all pins masked, swing them
      set_pins(8'hFF);
      chk("R2 irq while masked", 32'(irq_oe), 0);
      rd_exp(4'h6, 8'h00, "R2 status while masked");
      set_pins(8'h00);
      chk("R2 irq while masked back", 32'(irq_oe), 0);

      // R9, R10: push-pull outputs on the upper nibble
      wr(4'h1, 8'hA5);
      wr(4'h0, 8'h0F);
      chk("R9 push-pull enables", 32'(pin_oe), 32'hF0);
      chk("R9 push-pull level", 32'(pin_out), 32'hA5);
      rd_exp(4'h1, 8'hA5, "R10 out readback");

      // R8: open-drain on the same value
      wr(4'h7, 8'h01);
      chk("R8 od enables", 32'(pin_oe), 32'h50);
      chk("R8 od level", 32'(pin_out), 32'h00);
      rd_exp(4'h1, 8'hA5, "R10 out readback in od");
      wr(4'h7, 8'h00);

      // R4: inversion
      set_pins(8'h03);
      wr(4'h2, 8'h01);
      rd_exp(4'h3, 8'h02, "R4 inverted input");

      // R3, R5: unlatched interrupt on pin 0
      wr(4'h5, 8'hFE);
      @(negedge clk);
      chk("R3 no irq at unmask", 32'(irq_oe), 0);
      set_pins(8'h02);
      chk("R3 irq on change", 32'(irq_oe), 1);
      rd_exp(4'h6, 8'h01, "R3 status source");
      rd_exp(4'h6, 8'h01, "R7 status read no side effect");
      set_pins(8'h03);
      chk("R5 irq follows return", 32'(irq_oe), 0);
      set_pins(8'h02);
      chk("R3 irq second change", 32'(irq_oe), 1);
      rd_exp(4'h3, 8'h03, "R7 input read value");
      chk("R7 irq cleared by input read", 32'(irq_oe), 0);
      rd_exp(4'h6, 8'h00, "R7 status cleared");

      // R11: read-only addresses and plain storage
      wr(4'h6, 8'hFF);
      wr(4'h3, 8'hFF);
      rd_exp(4'h6, 8'h00, "R11 status write ignored");
      rd_exp(4'h3, 8'h03, "R11 input write ignored");
      wr(4'h8, 8'h3C);
      wr(4'h9, 8'hC3);
      rd_exp(4'h8, 8'h3C, "R11 pull enable storage");
      rd_exp(4'h9, 8'hC3, "R11 pull select storage");

      // R6: latched pin 1
      wr(4'h4, 8'h02);
      wr(4'h5, 8'hFC);
      @(negedge clk);
      chk("R6 no irq before change", 32'(irq_oe), 0);
      set_pins(8'h00);
      chk("R6 irq on latched change", 32'(irq_oe), 1);
      rd_exp(4'h6, 8'h02, "R6 latched status");
      set_pins(8'h02);
      chk("R6 irq held after return", 32'(irq_oe), 1);
      rd_exp(4'h6, 8'h02, "R6 status held after return");
      rd_exp(4'h3, 8'h01, "R6 read returns held level");
      chk("R7 irq cleared after latched read", 32'(irq_oe), 0);
      rd_exp(4'h3, 8'h03, "R7 next read shows live level");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 mid-run reset enables", 32'(pin_oe), 0);
      rst_n = 1'b1;
      rd_exp(4'h0, 8'hFF, "R1 dir after mid reset");
      rd_exp(4'h5, 8'hFF, "R1 mask after mid reset");
      rd_exp(4'h4, 8'h00, "R1 latch after mid reset");

      repeat (4) @(negedge clk);
      chk("scoreboard drained", 32'(sb.size()), 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule